// File: doc/BRIEF.md
# Self-Timed SRAM Read Sequencer

This controller steps an SRAM macro through the phases of a read access. While idle it holds the bit-line pair in precharge and equalize. A read request ends precharge and, on the next clock, raises the decoded row's word line together with a dummy-row word line that drives a replica column. The word-line phase ends when the replica column reports that its bit line has discharged past the sensing threshold. A programmable cycle limit acts as a backup if that report never comes.

Ending the word-line phase produces a single-cycle sense-amplifier enable. The sensed word is captured into an output register. Precharge resumes in the same cycle that the captured word is presented. The output of one access therefore overlaps the precharge of the next.

A request that arrives while an access is in flight is parked in a one-entry holding slot. It is launched from the first precharge cycle after the current access.

Top module: `sram_read_seq`

## Requirements
- R1: During and immediately after reset, `precharge` is 1 and `wl_en`, `wl_dummy`, `sae`, `rd_valid` and `timeout_flag` are 0.
- R2: `precharge` and `wl_en` are never 1 in the same cycle, and every rise of `wl_en` is preceded by at least one cycle with `precharge` at 1.
- R3: A request seen while idle (precharge phase, nothing held) raises `wl_en` and `wl_dummy` together on the next cycle, with `row_addr` equal to the requested address; `wl_dummy` always equals `wl_en`.
- R4: When `replica_done` is 1 during a word-line cycle, the next cycle has `wl_en` at 0 and `sae` at 1, and `sae` then lasts exactly one cycle.
- R5: `sae` is never 1 in a cycle where `wl_en` is 1, and is 1 only in the cycle right after a word-line cycle.
- R6: `rd_valid` is 1 for exactly the one cycle after each `sae` cycle, and in that cycle `rd_data` equals the `sense_data` value present during the `sae` cycle.
- R7: If `replica_done` stays 0, the word line stays up for `timeout_limit`+1 cycles, then the sense cycle follows and `timeout_flag` becomes 1 and stays 1 until reset.
- R8: An access ended by `replica_done` within the limit leaves `timeout_flag` unchanged.
- R9: A request made while an access is in progress is held and launched on the cycle after the next precharge cycle. A further request made while the slot is occupied is dropped and produces no word-line activity.
- R10: `precharge` returns to 1 in the cycle after `sae`, which is the same cycle as `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request, one cycle per read |
| req_addr | input | ADDR_W | Row address of the request |
| timeout_limit | input | TO_W | Extra word-line cycles allowed before a forced end |
| replica_done | input | 1 | Replica column has crossed its threshold |
| sense_data | input | DATA_W | Word from the sense amplifiers |
| precharge | output | 1 | Bit-line precharge and equalize |
| wl_en | output | 1 | Decoded row word-line enable |
| wl_dummy | output | 1 | Dummy row word-line enable |
| row_addr | output | ADDR_W | Row being accessed |
| sae | output | 1 | Sense-amplifier enable |
| rd_data | output | DATA_W | Registered read word |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| timeout_flag | output | 1 | Sticky: a word-line phase was ended by the limit |

## Verification
A phase register stuck or skipping a state is visible within one clock. It shows as precharge overlapping the word line, a missing or doubled sense pulse, or a word line that does not release on the cycle after the replica report. A corrupted counter shows as a word-line phase whose length differs from `timeout_limit`+1 on the first access that relies on the limit. A wrong holding-slot state shows either as a missing second access or as a spurious third access, within three cycles of the current sense pulse. A capture error shows as a wrong `rd_data` on the single `rd_valid` cycle.

// File: rtl/sram_read_seq.sv
module sram_read_seq #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int TO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TO_W-1:0]   timeout_limit,
  input  logic              replica_done,
  input  logic [DATA_W-1:0] sense_data,
  output logic              precharge,
  output logic              wl_en,
  output logic              wl_dummy,
  output logic [ADDR_W-1:0] row_addr,
  output logic              sae,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              timeout_flag
);

  typedef enum logic [1:0] {PH_PRE, PH_WL, PH_SENSE} phase_t;

  phase_t            ph;
  logic [TO_W-1:0]   wl_cnt;
  logic              hold_v;
  logic [ADDR_W-1:0] hold_addr;
  logic [ADDR_W-1:0] row_q;

  wire launch  = (ph == PH_PRE) && (req || hold_v);
  wire limit   = (ph == PH_WL) && (wl_cnt == timeout_limit);
  wire wl_stop = (ph == PH_WL) && (replica_done || limit);
  wire forced  = limit && !replica_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_PRE;
      wl_cnt <= '0;
      row_q  <= '0;
    end else begin
      case (ph)
        PH_PRE: if (launch) begin
          ph     <= PH_WL;
          row_q  <= hold_v ? hold_addr : req_addr;
          wl_cnt <= '0;
        end
        PH_WL: if (wl_stop) ph <= PH_SENSE;
               else         wl_cnt <= wl_cnt + 1'b1;
        default: ph <= PH_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_addr <= '0;
    end else if (ph == PH_PRE) begin
      if (hold_v) begin
        hold_v <= req;
        if (req) hold_addr <= req_addr;
      end
    end else if (req && !hold_v) begin
      hold_v    <= 1'b1;
      hold_addr <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      timeout_flag <= 1'b0;
    end else begin
      rd_valid <= (ph == PH_SENSE);
      if (ph == PH_SENSE) rd_data <= sense_data;
      if (forced) timeout_flag <= 1'b1;
    end
  end

  assign precharge = (ph == PH_PRE);
  assign wl_en     = (ph == PH_WL);
  assign wl_dummy  = wl_en;
  assign sae       = (ph == PH_SENSE);
  assign row_addr  = row_q;

endmodule

module sram_read_seq_chk #(
  parameter int TO_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            precharge,
  input logic            wl_en,
  input logic            wl_dummy,
  input logic            sae,
  input logic            rd_valid,
  input logic            replica_done,
  input logic            timeout_flag,
  input logic [TO_W-1:0] timeout_limit
);

  logic [TO_W:0] wl_run;
  always_ff @(posedge clk) begin
    if (!rst_n)     wl_run <= '0;
    else if (wl_en) wl_run <= wl_run + 1'b1;
    else            wl_run <= '0;
  end

  assert_pre_wl_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(precharge && wl_en));
  assert_pre_before_wl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_en) |-> $past(precharge));
  assert_dummy_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wl_dummy == wl_en);
  assert_done_ends_wl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_en && replica_done) |=> (!wl_en && sae));
  assert_sae_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sae |=> !sae);
  assert_sae_after_wl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sae |-> (!wl_en && $past(wl_en)));
  assert_valid_follows_sae_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(sae));
  assert_wl_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |-> (wl_run <= {1'b0, timeout_limit}));
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timeout_flag) |-> timeout_flag);
  assert_pre_after_sae_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sae |=> precharge);

endmodule

bind sram_read_seq sram_read_seq_chk #(.TO_W(TO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .precharge(precharge), .wl_en(wl_en),
  .wl_dummy(wl_dummy), .sae(sae), .rd_valid(rd_valid),
  .replica_done(replica_done), .timeout_flag(timeout_flag),
  .timeout_limit(timeout_limit)
);

// File: tb/tb_sram_read_seq.sv
module tb_sram_read_seq;
  localparam int AW = 6, DW = 8, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, replica_done = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] timeout_limit = 4'd15;
  logic [DW-1:0] sense_data;
  logic precharge, wl_en, wl_dummy, sae, rd_valid, timeout_flag;
  logic [AW-1:0] row_addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] mem [1<<AW];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign sense_data = sae ? mem[row_addr] : '0;

  sram_read_seq #(.ADDR_W(AW), .DATA_W(DW), .TO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .timeout_limit(timeout_limit), .replica_done(replica_done),
    .sense_data(sense_data), .precharge(precharge), .wl_en(wl_en),
    .wl_dummy(wl_dummy), .row_addr(row_addr), .sae(sae), .rd_data(rd_data),
    .rd_valid(rd_valid), .timeout_flag(timeout_flag)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 precharge", precharge, 1);
    chk("R1 wl", {wl_en, wl_dummy}, 0);
    chk("R1 sae/valid/flag", {sae, rd_valid, timeout_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {precharge, wl_en, sae, rd_valid}, 4'b1000);
  endtask

  // launches a read and ends it with replica_done in word-line cycle n
  task automatic t_read(input logic [AW-1:0] a, input int n);
    logic f0;
    f0 = timeout_flag;
    @(negedge clk);
    chk("R2 precharge before wl", precharge, 1);
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    chk("R3 wl_en/wl_dummy", {wl_en, wl_dummy}, 2'b11);
    chk("R3 row_addr", row_addr, a);
    chk("R2 no precharge with wl", precharge, 0);
    chk("R5 no sae on wl rise", sae, 0);
    repeat (n - 1) @(negedge clk);
    chk("R4 wl still up", wl_en, 1);
    replica_done = 1'b1;
    @(negedge clk);
    replica_done = 1'b0;
    chk("R4 wl released", wl_en, 0);
    chk("R4 sae", sae, 1);
    @(negedge clk);
    chk("R4 sae one cycle", sae, 0);
    chk("R6 rd_valid", rd_valid, 1);
    chk("R6 rd_data", rd_data, mem[a]);
    chk("R10 precharge with rd_valid", precharge, 1);
    @(negedge clk);
    chk("R6 rd_valid one cycle", rd_valid, 0);
    chk("R8 flag unchanged", timeout_flag, f0);
  endtask

  task automatic t_timeout(input logic [TW-1:0] lim, input logic [AW-1:0] a);
    int n;
    timeout_limit = lim;
    @(negedge clk);
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (wl_en && n < 40) begin n++; @(negedge clk); end
    chk("R7 wl length", n, lim + 1);
    chk("R7 sae after limit", sae, 1);
    chk("R7 flag set", timeout_flag, 1);
    @(negedge clk);
    chk("R7 data after timeout", rd_data, mem[a]);
    timeout_limit = 4'd15;
    t_read(6'd9, 2);
    chk("R7 flag sticky", timeout_flag, 1);
  endtask

  task automatic t_pending(input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic [AW-1:0] c);
    int extra;
    @(negedge clk);
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req_addr = b;
    @(negedge clk);
    req_addr = c;
    @(negedge clk);
    req = 1'b0;
    chk("R9 first access row", row_addr, a);
    replica_done = 1'b1;
    @(negedge clk);
    replica_done = 1'b0;
    chk("R9 sae first", sae, 1);
    @(negedge clk);
    chk("R9 precharge between", precharge, 1);
    chk("R9 data first", rd_data, mem[a]);
    @(negedge clk);
    chk("R9 held request launched", wl_en, 1);
    chk("R9 held row", row_addr, b);
    replica_done = 1'b1;
    @(negedge clk);
    replica_done = 1'b0;
    @(negedge clk);
    chk("R9 data second", rd_data, mem[b]);
    extra = 0;
    repeat (5) begin @(negedge clk); if (wl_en) extra++; end
    chk("R9 third request dropped", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 5);
    t_reset();
    t_read(6'd3, 1);
    t_read(6'd63, 4);
    t_read(6'd0, 15);
    t_read(6'd42, 2);
    t_timeout(4'd3, 6'd17);
    t_timeout(4'd0, 6'd30);
    t_pending(6'd5, 6'd50, 6'd7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule